// File: doc/BRIEF.md
# Lockable Identification Page Controller

This block owns a single 256-byte side page that lives next to a serial memory's main array. A slave front end, which handles the serial bit engine, hands it already-decoded events: a transaction start addressed to the auxiliary device type (with its read/write flag), each received byte, each request for an outgoing read byte, and a commit pulse. The commit pulse marks a stop that lands directly after a data-byte acknowledge slot. For every received byte the block answers with an acknowledge decision. For every read request it returns the byte under its internal pointer. It also reports whether the page has been frozen.

The page comes out of reset holding a three-byte identification code at offsets 00h..02h (20h, E0h, 11h). Every other byte reads FFh. Software may overwrite any byte with page-write semantics: bytes are staged as they arrive, wrap within the page, and land together at the commit. Bit 2 of the upper address byte (address bit 10) chooses the mode. When it is 0, the transaction is a data access. When it is 1, the transaction is the one-byte lock command. A lock command whose data bit 1 is set freezes the page permanently at its commit. After that, data bytes of any write transaction are refused. This refusal is also how the lock state is queried over the bus.

The state machine has seven states. IDLE waits for a start. ADDR_HI takes the upper address byte and latches bit 10. ADDR_LO takes the byte index and loads the pointer. WR_DATA stages page-write bytes. LOCK_DATA takes the single lock byte. LOCK_HELD refuses any further bytes of a lock transaction. RD_DATA serves read requests. The transitions are as follows:
- Any start goes to ADDR_HI, or to RD_DATA when its read flag is set.
- ADDR_HI goes to ADDR_LO on a byte.
- ADDR_LO goes to WR_DATA on a byte when bit 10 was 0, and to LOCK_DATA when it was 1.
- LOCK_DATA goes to LOCK_HELD on a byte.
- A commit from any state returns to IDLE.

Top module: `idp_ctrl`

## Requirements
- R1: After reset, `locked` is 0 and the page reads 20h, E0h, 11h at offsets 00h, 01h, 02h and FFh everywhere else; a read issued before any address starts at offset 00h.
- R2: Both address bytes are always acknowledged (`ack_vld`=1, `ack`=1). Only bit 2 of the upper byte is decoded, and the lower byte is the byte offset.
- R3: Write data bytes are staged and reach the page only at `commit`; bytes followed by a new start instead of a commit leave the page unchanged.
- R4: The write offset increments per byte and wraps from FFh to 00h, so a write longer than the remaining page overwrites its first bytes.
- R5: A read start after an address phase reads from that offset. Each `rd_req` returns the next byte and wraps at FFh. A read start with no address phase continues from the current pointer.
- R6: While locked, write data bytes get `ack`=0 and a commit changes nothing. A data byte sent after an address with bit 10 = 0 therefore reports the lock state (ack 1 = unlocked, 0 = locked).
- R7: A lock command (upper address bit 2 = 1) whose first data byte has bit 1 = 1 sets `locked` at the commit edge and not before. `locked` then stays 1 until reset.
- R8: A lock command data byte with bit 1 = 0 is acknowledged and leaves `locked` at 0.
- R9: In a lock transaction, bytes after the first get `ack`=0. A lock data byte received while already locked also gets `ack`=0.
- R10: `ack_vld`/`ack` appear one cycle after `byte_vld`, and `rd_vld`/`rd_data` one cycle after `rd_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_vld | input | 1 | Pulse: new transaction to the auxiliary device type |
| start_rd | input | 1 | Read flag of that start (1 = read) |
| byte_vld | input | 1 | Pulse: a received byte is on `byte_in` |
| byte_in | input | 8 | Received address or data byte |
| rd_req | input | 1 | Pulse: front end needs the next read byte |
| commit | input | 1 | Pulse: stop right after a data acknowledge slot |
| ack_vld | output | 1 | Acknowledge decision valid |
| ack | output | 1 | 1 = acknowledge, 0 = no acknowledge |
| rd_vld | output | 1 | Read byte valid |
| rd_data | output | 8 | Read byte |
| locked | output | 1 | Page is permanently read-only |

## Verification
The hardest case to reach is the window between a lock byte's arrival and its commit. Here the page must still look unlocked while a second byte of the same transaction is already refused. The bench sends a valid lock byte and then an extra byte. It checks both acknowledges and confirms `locked` is still 0 before issuing the commit. Every offset is covered by a full-page wrapped write and read-back, with expected bytes computed from an arithmetic pattern. Several upper-address values then show that only bit 10 matters.

// File: rtl/idp_pkg.sv
package idp_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR_HI,
        S_ADDR_LO,
        S_WR_DATA,
        S_LOCK_DATA,
        S_LOCK_HELD,
        S_RD_DATA
    } idp_state_e;
endpackage

// File: rtl/idp_fsm.sv
module idp_fsm
    import idp_pkg::*;
#(
    parameter int AW       = 8,
    parameter int SEL_BIT  = 2,
    parameter int LOCK_BIT = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_vld,
    input  logic          start_rd,
    input  logic          byte_vld,
    input  logic [7:0]    byte_in,
    input  logic          rd_req,
    input  logic          commit,
    input  logic          locked_i,
    output logic          ack_vld,
    output logic          ack,
    output logic          stage_we,
    output logic          stage_clr,
    output logic [AW-1:0] stage_idx,
    output logic [7:0]    stage_data,
    output logic          apply_go,
    output logic          lock_go,
    output logic          rd_go,
    output logic [AW-1:0] rd_idx
);
    idp_state_e    state, state_nx;
    logic [AW-1:0] ptr;
    logic          lock_sel;
    logic          lock_req;
    logic          byte_ev;

    assign byte_ev = byte_vld && !start_vld;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // next-state decode
    always_comb begin
        state_nx = state;
        if (start_vld) begin
            state_nx = start_rd ? S_RD_DATA : S_ADDR_HI;
        end else if (commit) begin
            state_nx = S_IDLE;
        end else if (byte_vld) begin
            unique case (state)
                S_ADDR_HI:   state_nx = S_ADDR_LO;
                S_ADDR_LO:   state_nx = lock_sel ? S_LOCK_DATA : S_WR_DATA;
                S_LOCK_DATA: state_nx = S_LOCK_HELD;
                default:     state_nx = state;
            endcase
        end
    end

    // strobes toward the page store
    always_comb begin
        stage_clr  = start_vld;
        stage_we   = byte_ev && (state == S_WR_DATA) && !locked_i;
        stage_idx  = ptr;
        stage_data = byte_in;
        apply_go   = commit && !start_vld && (state == S_WR_DATA) && !locked_i;
        lock_go    = commit && !start_vld && (state == S_LOCK_HELD) && lock_req;
        rd_go      = rd_req && !start_vld && (state == S_RD_DATA);
        rd_idx     = ptr;
    end

    // registered outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_vld  <= 1'b0;
            ack      <= 1'b0;
            ptr      <= '0;
            lock_sel <= 1'b0;
            lock_req <= 1'b0;
        end else begin
            ack_vld <= 1'b0;
            ack     <= 1'b0;
            if (start_vld) begin
                lock_req <= 1'b0;
            end else if (byte_vld) begin
                unique case (state)
                    S_ADDR_HI: begin
                        ack_vld  <= 1'b1;
                        ack      <= 1'b1;
                        lock_sel <= byte_in[SEL_BIT];
                    end
                    S_ADDR_LO: begin
                        ack_vld <= 1'b1;
                        ack     <= 1'b1;
                        ptr     <= byte_in[AW-1:0];
                    end
                    S_WR_DATA: begin
                        ack_vld <= 1'b1;
                        ack     <= !locked_i;
                        ptr     <= ptr + 1'b1;
                    end
                    S_LOCK_DATA: begin
                        ack_vld  <= 1'b1;
                        ack      <= !locked_i;
                        lock_req <= byte_in[LOCK_BIT] && !locked_i;
                    end
                    S_LOCK_HELD: begin
                        ack_vld <= 1'b1;
                        ack     <= 1'b0;
                    end
                    default: ;
                endcase
            end
            if (rd_go) ptr <= ptr + 1'b1;
        end
    end

    // R2: address bytes are always acknowledged
    p_addr_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_ev && (state == S_ADDR_HI || state == S_ADDR_LO)) |=> (ack_vld && ack));

    // R6: a locked page refuses write data
    p_data_nak_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_ev && state == S_WR_DATA && locked_i) |=> (ack_vld && !ack));

    // R9: extra bytes of a lock transaction are refused
    p_extra_lock_nak_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_ev && state == S_LOCK_HELD) |=> (ack_vld && !ack));
endmodule

// File: rtl/idp_store.sv
module idp_store #(
    parameter int          DEPTH   = 256,
    parameter int          AW      = 8,
    parameter logic [23:0] ID_CODE = 24'h20E011
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stage_we,
    input  logic          stage_clr,
    input  logic [AW-1:0] stage_idx,
    input  logic [7:0]    stage_data,
    input  logic          apply_go,
    input  logic          lock_go,
    input  logic          rd_go,
    input  logic [AW-1:0] rd_idx,
    output logic          locked,
    output logic          rd_vld,
    output logic [7:0]    rd_data
);
    logic [7:0]       page  [DEPTH];
    logic [7:0]       stage [DEPTH];
    logic [DEPTH-1:0] mask;

    function automatic logic [7:0] init_byte(input int k);
        case (k)
            0:       return ID_CODE[23:16];
            1:       return ID_CODE[15:8];
            2:       return ID_CODE[7:0];
            default: return 8'hFF;
        endcase
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) page[i] <= init_byte(i);
        end else if (apply_go) begin
            for (int i = 0; i < DEPTH; i++)
                if (mask[i]) page[i] <= stage[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                     mask <= '0;
        else if (stage_clr || apply_go) mask <= '0;
        else if (stage_we)              mask[stage_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (stage_we) stage[stage_idx] <= stage_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked  <= 1'b0;
            rd_vld  <= 1'b0;
            rd_data <= '0;
        end else begin
            if (lock_go) locked <= 1'b1;
            rd_vld <= rd_go;
            if (rd_go) rd_data <= page[rd_idx];
        end
    end

    // R7: the lock never clears outside reset
    p_lock_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);
endmodule

// File: rtl/idp_ctrl.sv
module idp_ctrl #(
    parameter int          PAGE_BYTES = 256,
    parameter logic [23:0] ID_CODE    = 24'h20E011,
    parameter int          SEL_BIT    = 2,
    parameter int          LOCK_BIT   = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_vld,
    input  logic       start_rd,
    input  logic       byte_vld,
    input  logic [7:0] byte_in,
    input  logic       rd_req,
    input  logic       commit,
    output logic       ack_vld,
    output logic       ack,
    output logic       rd_vld,
    output logic [7:0] rd_data,
    output logic       locked
);
    localparam int AW = $clog2(PAGE_BYTES);

    logic          stage_we, stage_clr, apply_go, lock_go, rd_go;
    logic [AW-1:0] stage_idx, rd_idx;
    logic [7:0]    stage_data;

    idp_fsm #(.AW(AW), .SEL_BIT(SEL_BIT), .LOCK_BIT(LOCK_BIT)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .start_vld(start_vld), .start_rd(start_rd),
        .byte_vld(byte_vld), .byte_in(byte_in),
        .rd_req(rd_req), .commit(commit), .locked_i(locked),
        .ack_vld(ack_vld), .ack(ack),
        .stage_we(stage_we), .stage_clr(stage_clr),
        .stage_idx(stage_idx), .stage_data(stage_data),
        .apply_go(apply_go), .lock_go(lock_go),
        .rd_go(rd_go), .rd_idx(rd_idx)
    );

    idp_store #(.DEPTH(PAGE_BYTES), .AW(AW), .ID_CODE(ID_CODE)) u_store (
        .clk(clk), .rst_n(rst_n),
        .stage_we(stage_we), .stage_clr(stage_clr),
        .stage_idx(stage_idx), .stage_data(stage_data),
        .apply_go(apply_go), .lock_go(lock_go),
        .rd_go(rd_go), .rd_idx(rd_idx),
        .locked(locked), .rd_vld(rd_vld), .rd_data(rd_data)
    );

    // R7: the lock rises only on a commit edge
    p_lock_at_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(commit));

    // R10: read data answers a request of the previous cycle
    p_rd_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_vld |-> $past(rd_req));
endmodule

// File: tb/idp_ctrl_bench.sv
module idp_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_vld = 1'b0, start_rd = 1'b0, byte_vld = 1'b0;
    logic [7:0] byte_in = '0;
    logic       rd_req = 1'b0, commit = 1'b0;
    logic       ack_vld, ack, rd_vld, locked;
    logic [7:0] rd_data;

    int         n_chk = 0;
    int         n_err = 0;
    logic [7:0] exp_pg [256];

    always #5 clk = ~clk;

    idp_ctrl u_idp_ctrl (
        .clk(clk), .rst_n(rst_n), .start_vld(start_vld), .start_rd(start_rd),
        .byte_vld(byte_vld), .byte_in(byte_in), .rd_req(rd_req), .commit(commit),
        .ack_vld(ack_vld), .ack(ack), .rd_vld(rd_vld), .rd_data(rd_data),
        .locked(locked)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_start(input logic rd);
        @(posedge clk); #1 start_vld = 1'b1; start_rd = rd;
        @(posedge clk); #1 start_vld = 1'b0; start_rd = 1'b0;
    endtask

    task automatic do_commit();
        @(posedge clk); #1 commit = 1'b1;
        @(posedge clk); #1 commit = 1'b0;
    endtask

    // send a byte and check its acknowledge one cycle later (R10)
    task automatic send(input logic [7:0] b, input logic exp_ack, input string tag);
        @(posedge clk); #1 byte_vld = 1'b1; byte_in = b;
        @(posedge clk); #1 byte_vld = 1'b0;
        chk({tag, " R10 ack_vld"}, ack_vld, 1);
        chk({tag, " ack"}, ack, exp_ack);
    endtask

    task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo);
        do_start(1'b0);
        send(hi, 1'b1, "R2 upper");
        send(lo, 1'b1, "R2 lower");
    endtask

    task automatic read_run(input logic [7:0] lo, input int cnt, input string tag);
        for (int k = 0; k < cnt; k++) begin
            @(posedge clk); #1 rd_req = 1'b1;
            @(posedge clk); #1 rd_req = 1'b0;
            chk({tag, " R10 rd_vld"}, rd_vld, 1);
            chk(tag, rd_data, exp_pg[(lo + k) % 256]);
        end
    endtask

    task automatic read_at(input logic [7:0] hi, input logic [7:0] lo, input int cnt,
                           input string tag);
        set_addr(hi, lo);
        do_start(1'b1);
        read_run(lo, cnt, tag);
    endtask

    function automatic logic [7:0] pat(input int k);
        return 8'((k * 37 + 11) & 255);
    endfunction

    initial begin
        for (int i = 0; i < 256; i++) exp_pg[i] = (i == 0) ? 8'h20 : (i == 1) ? 8'hE0 :
                                                 (i == 2) ? 8'h11 : 8'hFF;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        chk("R1 locked after reset", locked, 0);
        chk("R1 no ack after reset", ack_vld, 0);

        // R1: read with no address phase starts at offset 0
        do_start(1'b1);
        read_run(8'h00, 3, "R1 id code");
        // R1/R5: full sequential read of the delivered page
        read_at(8'h00, 8'h00, 256, "R1 R5 initial page");

        // R4: full-page write from 80h wraps; upper bits other than bit 2 set
        set_addr(8'hFB, 8'h80);
        for (int k = 0; k < 256; k++) send(pat(k), 1'b1, "R3 write data");
        do_commit();
        for (int k = 0; k < 256; k++) exp_pg[(8'h80 + k) % 256] = pat(k);
        read_at(8'h00, 8'h40, 256, "R4 R5 wrapped read");
        // R5: current-address read continues at 40h after the 256-byte wrap
        do_start(1'b1);
        read_run(8'h40, 2, "R5 current address");

        // R4: short write across the page end
        set_addr(8'h03, 8'hFE);
        send(8'hAA, 1'b1, "R4 data"); send(8'hBB, 1'b1, "R4 data"); send(8'hCC, 1'b1, "R4 data");
        do_commit();
        exp_pg[8'hFE] = 8'hAA; exp_pg[8'hFF] = 8'hBB; exp_pg[8'h00] = 8'hCC;
        read_at(8'hF8, 8'hFE, 3, "R4 page-end wrap");

        // R3: bytes without commit are dropped
        set_addr(8'h00, 8'h10);
        send(8'h55, 1'b1, "R3 data"); send(8'h66, 1'b1, "R3 data");
        read_at(8'h00, 8'h10, 2, "R3 uncommitted");

        // R8: lock byte with bit 1 clear
        set_addr(8'h04, 8'h00);
        send(8'hFD, 1'b1, "R8 lock byte bit1=0");
        do_commit();
        chk("R8 still unlocked", locked, 0);
        set_addr(8'h00, 8'h30);
        send(8'h77, 1'b1, "R8 write after");
        do_commit();
        exp_pg[8'h30] = 8'h77;
        read_at(8'h00, 8'h30, 1, "R8 still writable");

        // R7/R9: real lock, extra byte refused, effect only at commit
        set_addr(8'hFF, 8'h12);
        send(8'h02, 1'b1, "R7 lock byte");
        send(8'hFF, 1'b0, "R9 extra lock byte");
        chk("R7 not locked before commit", locked, 0);
        do_commit();
        chk("R7 locked at commit", locked, 1);

        // R6: locked page refuses writes
        set_addr(8'h00, 8'h20);
        for (int k = 0; k < 3; k++) send(8'h99, 1'b0, "R6 locked write");
        do_commit();
        read_at(8'h00, 8'h20, 3, "R6 page unchanged");
        chk("R7 stays locked", locked, 1);

        // R6: lock status query through data acknowledge
        set_addr(8'h00, 8'h00);
        send(8'h00, 1'b0, "R6 status query");
        // R9: lock byte when already locked
        set_addr(8'h04, 8'h00);
        send(8'h02, 1'b0, "R9 relock byte");
        do_commit();
        chk("R7 locked after relock", locked, 1);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule